// File: doc/BRIEF.md
# Serial Port Register Block

This block is the register front end of a simple serial port. A processor talks to it over a single-cycle, 32-bit, word-addressed register bus. The line side hands it received bytes over a valid/ready stream and takes transmit bytes as a one-cycle strobe. Bit-level framing and baud timing sit outside this block. Received bytes queue in a 16-entry circular FIFO. Software drains the FIFO through two status/data windows. The first removes the oldest byte when it is read. The second only looks at it.

Interrupts are kept in a raw register. A mask register gates them, and an acknowledge register clears them. One line reports whether any unmasked cause is pending. A write to the data-out register produces the transmit strobe and raises the transmit causes. The first acknowledge after a transmit spares the transmit-done bit (bit 0). Software therefore needs two acknowledges to clear it.

Receive stream rules: a byte moves only in a cycle where both `rx_valid` and `rx_ready` are high. `rx_ready` is dropped whenever receive is disabled or the FIFO is full, so the sender holds its byte. The transmit strobe has no back-pressure. `tx_valid` is high for exactly one cycle per data-out write.

Top module: `serport_regs`

## Requirements
- R1: After reset, the receive control word (word 2) reads 0x00010000. Every other register reads zero, the FIFO is empty, `rx_ready` is low and `irq` is low.
- R2: The FIFO holds up to 16 bytes and returns them oldest first. While it holds 16, `rx_ready` is low and no byte is taken.
- R3: A read of word 8 or word 9 returns a status word. Bits 7:0 hold the oldest byte, or zero when the FIFO is empty. Bit 16 is 1 when the FIFO is non-empty. Bits 22 and 24 are always 1. All other bits are 0.
- R4: A read of word 8 removes the oldest byte when the FIFO is non-empty. A read of word 9 never changes the FIFO.
- R5: `rx_ready` is high only while bit 3 of the receive control word is 1 and the FIFO is not full. A byte is stored in each cycle where `rx_valid` and `rx_ready` are both high.
- R6: A write to word 7 stores the value and raises `tx_valid` for one cycle on the next cycle, with `tx_data` set to the low byte. The write also sets raw bits 0 and 1 and arms a pending-transmit flag.
- R7: A write to word 12 (acknowledge) clears each raw bit written as 1. If the pending flag is armed, bit 0 of the write is dropped and the flag is cleared. Word 12 reads back the value that was actually applied.
- R8: Raw bit 3 (word 13) is reloaded with "FIFO non-empty" after every bus write and every accepted byte. A pop-read alone does not reload it.
- R9: Word 14 reads raw AND mask (mask is word 11). `irq` is high exactly when that AND is non-zero.
- R10: Words 0, 1, 2 and 11 read back the last value written. Writes to words 13 and 14 are ignored. Unlisted words read zero and ignore writes.
- R11: When a byte is accepted in the same cycle as a pop-read, the count is unchanged and byte order is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 4 | Word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during a read cycle, else zero |
| rx_valid | input | 1 | Received byte offered |
| rx_ready | output | 1 | Block can take a byte |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | One-cycle transmit strobe |
| tx_data | output | 8 | Byte to transmit |
| irq | output | 1 | Any masked interrupt pending |

## Verification
A wrong FIFO pointer or count shows up as a wrong byte or a wrong bit 16 on the very next status read. It also shows up as `rx_ready` at the wrong level in the same cycle. A broken pending flag or raw register shows up at word 13 and on `irq` one cycle after the acknowledge or data-out write. The bench compares every port against its queue-based model on every clock. A divergence is therefore reported within one cycle of the cause once the bus or the stream exposes it.

// File: rtl/serport_pkg.sv
package serport_pkg;
  localparam int unsigned BUS_DW = 32;
  localparam int unsigned BYTE_W = 8;

  // word indices (byte offset / 4)
  localparam logic [3:0] W_TXCTL = 4'h0;
  localparam logic [3:0] W_TXDMA = 4'h1;
  localparam logic [3:0] W_RXCTL = 4'h2;
  localparam logic [3:0] W_DOUT  = 4'h7;
  localparam logic [3:0] W_POP   = 4'h8;
  localparam logic [3:0] W_PEEK  = 4'h9;
  localparam logic [3:0] W_MASK  = 4'hB;
  localparam logic [3:0] W_ACK   = 4'hC;
  localparam logic [3:0] W_RAW   = 4'hD;
  localparam logic [3:0] W_MSKD  = 4'hE;

  localparam int unsigned ST_AVAIL = 16;
  localparam int unsigned ST_IDLE  = 22;
  localparam int unsigned ST_READY = 24;
  localparam int unsigned RXEN_BIT = 3;
  localparam int unsigned RAW_RXQ  = 3;
  localparam logic [BUS_DW-1:0] RXCTL_INIT = 32'h0001_0000;

  typedef enum logic [3:0] {
    SEL_TXCTL, SEL_TXDMA, SEL_RXCTL, SEL_DOUT, SEL_POP, SEL_PEEK,
    SEL_MASK, SEL_ACK, SEL_RAW, SEL_MSKD, SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_word(input logic [3:0] w);
    case (w)
      W_TXCTL: decode_word = SEL_TXCTL;
      W_TXDMA: decode_word = SEL_TXDMA;
      W_RXCTL: decode_word = SEL_RXCTL;
      W_DOUT:  decode_word = SEL_DOUT;
      W_POP:   decode_word = SEL_POP;
      W_PEEK:  decode_word = SEL_PEEK;
      W_MASK:  decode_word = SEL_MASK;
      W_ACK:   decode_word = SEL_ACK;
      W_RAW:   decode_word = SEL_RAW;
      W_MSKD:  decode_word = SEL_MSKD;
      default: decode_word = SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/serport_rxq.sv
module serport_rxq #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [DW-1:0]              push_data,
  input  logic                       pop,
  output logic [DW-1:0]              head,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       full,
  output logic                       empty,
  output logic                       nonempty_next
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  // oldest entry lives at write pointer minus count, wrapping
  assign rd_ptr = wr_ptr - cnt_q[AW-1:0];
  assign head   = mem[rd_ptr];
  assign count  = cnt_q;
  assign full   = (cnt_q == FULL_CNT);
  assign empty  = (cnt_q == '0);

  always_comb begin
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end
  assign nonempty_next = (cnt_d != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (push) wr_ptr <= wr_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end
endmodule

// File: rtl/serport_irq.sv
module serport_irq #(
  parameter int unsigned DW      = 32,
  parameter int unsigned RXQ_BIT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dout_we,
  input  logic          ack_we,
  input  logic          any_we,
  input  logic          rx_push,
  input  logic          rxq_nonempty_next,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] mask,
  output logic [DW-1:0] raw,
  output logic [DW-1:0] masked,
  output logic [DW-1:0] ack_val,
  output logic          irq
);
  logic [DW-1:0] raw_q, raw_d, ack_q, ack_apply;
  logic          pend_q, pend_d;

  always_comb begin
    raw_d     = raw_q;
    pend_d    = pend_q;
    ack_apply = pend_q ? (wdata & ~DW'(1)) : wdata;
    if (dout_we) begin
      raw_d[1:0] = 2'b11;
      pend_d     = 1'b1;
    end
    if (ack_we) begin
      raw_d  = raw_d & ~ack_apply;
      pend_d = 1'b0;
    end
    if (any_we || rx_push) raw_d[RXQ_BIT] = rxq_nonempty_next;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q  <= '0;
      ack_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      raw_q  <= raw_d;
      pend_q <= pend_d;
      if (ack_we) ack_q <= ack_apply;
    end
  end

  assign raw     = raw_q;
  assign masked  = raw_q & mask;
  assign ack_val = ack_q;
  assign irq     = |masked;
endmodule

// File: rtl/serport_regs.sv
module serport_regs
  import serport_pkg::*;
#(
  parameter int unsigned RXQ_DEPTH = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [3:0]          bus_word,
  input  logic [BUS_DW-1:0]   bus_wdata,
  output logic [BUS_DW-1:0]   bus_rdata,
  input  logic                rx_valid,
  output logic                rx_ready,
  input  logic [BYTE_W-1:0]   rx_data,
  output logic                tx_valid,
  output logic [BYTE_W-1:0]   tx_data,
  output logic                irq
);
  localparam int unsigned QCW = $clog2(RXQ_DEPTH) + 1;

  reg_sel_e          sel;
  logic              wr_cyc, rd_cyc;
  logic [BUS_DW-1:0] txctl_q, txdma_q, rxctl_q, dout_q, mask_q;
  logic              rx_en, push, pop;
  logic [BYTE_W-1:0] q_head;
  logic [QCW-1:0]    q_count;
  logic              q_full, q_empty, q_ne_next;
  logic [BUS_DW-1:0] raw, masked, ack_val, status;
  logic              tx_v_q;
  logic [BYTE_W-1:0] tx_d_q;

  assign sel    = decode_word(bus_word);
  assign wr_cyc = bus_sel & bus_wr;
  assign rd_cyc = bus_sel & ~bus_wr;

  assign rx_en    = rxctl_q[RXEN_BIT];
  assign rx_ready = rx_en & ~q_full;
  assign push     = rx_valid & rx_ready;
  assign pop      = rd_cyc & (sel == SEL_POP) & ~q_empty;

  serport_rxq #(.DEPTH(RXQ_DEPTH), .DW(BYTE_W)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(rx_data), .pop(pop),
    .head(q_head), .count(q_count), .full(q_full), .empty(q_empty),
    .nonempty_next(q_ne_next)
  );

  serport_irq #(.DW(BUS_DW), .RXQ_BIT(RAW_RXQ)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .dout_we(wr_cyc && sel == SEL_DOUT),
    .ack_we(wr_cyc && sel == SEL_ACK),
    .any_we(wr_cyc), .rx_push(push), .rxq_nonempty_next(q_ne_next),
    .wdata(bus_wdata), .mask(mask_q),
    .raw(raw), .masked(masked), .ack_val(ack_val), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txctl_q <= '0;
      txdma_q <= '0;
      rxctl_q <= RXCTL_INIT;
      dout_q  <= '0;
      mask_q  <= '0;
      tx_v_q  <= 1'b0;
      tx_d_q  <= '0;
    end else begin
      tx_v_q <= 1'b0;
      if (wr_cyc) begin
        case (sel)
          SEL_TXCTL: txctl_q <= bus_wdata;
          SEL_TXDMA: txdma_q <= bus_wdata;
          SEL_RXCTL: rxctl_q <= bus_wdata;
          SEL_MASK:  mask_q  <= bus_wdata;
          SEL_DOUT: begin
            dout_q <= bus_wdata;
            tx_v_q <= 1'b1;
            tx_d_q <= bus_wdata[BYTE_W-1:0];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    status                 = '0;
    status[ST_READY]       = 1'b1;
    status[ST_IDLE]        = 1'b1;
    status[ST_AVAIL]       = ~q_empty;
    status[BYTE_W-1:0]     = q_empty ? '0 : q_head;
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_cyc) begin
      case (sel)
        SEL_TXCTL:         bus_rdata = txctl_q;
        SEL_TXDMA:         bus_rdata = txdma_q;
        SEL_RXCTL:         bus_rdata = rxctl_q;
        SEL_DOUT:          bus_rdata = dout_q;
        SEL_POP, SEL_PEEK: bus_rdata = status;
        SEL_MASK:          bus_rdata = mask_q;
        SEL_ACK:           bus_rdata = ack_val;
        SEL_RAW:           bus_rdata = raw;
        SEL_MSKD:          bus_rdata = masked;
        default:           bus_rdata = '0;
      endcase
    end
  end

  assign tx_valid = tx_v_q;
  assign tx_data  = tx_d_q;
endmodule

// File: rtl/serport_regs_chk.sv
module serport_regs_chk
  import serport_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          bus_sel,
  input logic                          bus_wr,
  input logic [3:0]                    bus_word,
  input logic [BUS_DW-1:0]             bus_wdata,
  input logic [BUS_DW-1:0]             bus_rdata,
  input logic                          rx_valid,
  input logic                          rx_ready,
  input logic                          tx_valid,
  input logic [BYTE_W-1:0]             tx_data,
  input logic                          irq,
  input logic                          rx_en,
  input logic [$clog2(DEPTH):0]        q_count,
  input logic [BUS_DW-1:0]             mask_q
);
  localparam int unsigned CW = $clog2(DEPTH) + 1;
  logic rd_pop, rd_peek, dout_wr, acc;
  assign rd_pop  = bus_sel && !bus_wr && bus_word == W_POP;
  assign rd_peek = bus_sel && !bus_wr && bus_word == W_PEEK;
  assign dout_wr = bus_sel && bus_wr && bus_word == W_DOUT;
  assign acc     = rx_valid && rx_ready;

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CW'(DEPTH));

  assert_full_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (q_count == CW'(DEPTH)) |-> !rx_ready);

  assert_status_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop || rd_peek) |-> (bus_rdata[ST_READY] && bus_rdata[ST_IDLE]));

  assert_peek_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_peek && !acc) |=> $stable(q_count));

  assert_pop_removes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && q_count != '0 && !acc) |=> q_count == $past(q_count) - 1'b1);

  assert_rx_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> !rx_ready);

  assert_tx_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dout_wr |=> (tx_valid && tx_data == $past(bus_wdata[BYTE_W-1:0])));

  assert_tx_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!dout_wr) |=> !tx_valid);

  assert_irq_needs_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_q != '0));

  assert_push_pop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && q_count != '0 && acc) |=> $stable(q_count));
endmodule

bind serport_regs serport_regs_chk #(.DEPTH(RXQ_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .tx_valid(tx_valid),
  .tx_data(tx_data), .irq(irq), .rx_en(rx_en), .q_count(q_count),
  .mask_q(mask_q)
);

// File: tb/test_serport_regs.sv
module test_serport_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_word = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0, rx_ready;
  logic [7:0]  rx_data = '0;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  serport_regs i_serport_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
  );

  // ---------------- behavioural reference ----------------
  byte unsigned q[$];
  logic [31:0] m_txctl, m_txdma, m_rxctl, m_dout, m_mask, m_ack, m_raw;
  bit          m_pend, m_txv;
  logic [7:0]  m_txd;

  function automatic bit m_ready();
    return m_rxctl[3] && q.size() < 16;
  endfunction

  function automatic logic [31:0] m_read(input logic [3:0] w);
    logic [31:0] st;
    st = 32'h0140_0000;
    if (q.size() != 0) st = st | 32'h0001_0000 | 32'(q[0]);
    case (w)
      4'h0: return m_txctl;
      4'h1: return m_txdma;
      4'h2: return m_rxctl;
      4'h7: return m_dout;
      4'h8, 4'h9: return st;
      4'hB: return m_mask;
      4'hC: return m_ack;
      4'hD: return m_raw;
      4'hE: return m_raw & m_mask;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] w);
    case (w)
      4'h8, 4'h9: return "R3";
      4'hC: return "R7";
      4'hD: return "R8";
      4'hE: return "R9";
      4'h7: return "R6";
      default: return "R10";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_txctl = 0; m_txdma = 0; m_rxctl = 32'h0001_0000; m_dout = 0;
      m_mask = 0; m_ack = 0; m_raw = 0; m_pend = 0; m_txv = 0; m_txd = 0;
    end else begin
      bit acc;
      logic [31:0] v;
      acc = rx_valid && m_ready();
      m_txv = 0;
      if (bus_sel && !bus_wr && bus_word == 4'h8 && q.size() != 0) void'(q.pop_front());
      if (acc) q.push_back(rx_data);
      if (bus_sel && bus_wr) begin
        case (bus_word)
          4'h0: m_txctl = bus_wdata;
          4'h1: m_txdma = bus_wdata;
          4'h2: m_rxctl = bus_wdata;
          4'hB: m_mask  = bus_wdata;
          4'h7: begin
            m_dout = bus_wdata; m_raw[1:0] = 2'b11; m_pend = 1;
            m_txv = 1; m_txd = bus_wdata[7:0];
          end
          4'hC: begin
            v = bus_wdata;
            if (m_pend) v[0] = 1'b0;
            m_pend = 0; m_ack = v; m_raw = m_raw & ~v;
          end
          default: ;
        endcase
      end
      if ((bus_sel && bus_wr) || acc) m_raw[3] = (q.size() != 0);
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(32'(rx_ready), 32'(m_ready()), "R5 rx_ready");
      check(32'(irq), 32'(|(m_raw & m_mask)), "R9 irq");
      check(32'(tx_valid), 32'(m_txv), "R6 tx_valid");
      if (m_txv) check(32'(tx_data), 32'(m_txd), "R6 tx_data");
      if (bus_sel && !bus_wr) check(bus_rdata, m_read(bus_word), tag_of(bus_word));
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [3:0] w, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_word = w; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] w, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_word = w;
    @(negedge clk); d = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 0;
  endtask

  task automatic push(input logic [7:0] b);
    rx_valid = 1; rx_data = b;
    @(posedge clk); #1;
    rx_valid = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1: reset state
    rd(4'h2, d); check(d, 32'h0001_0000, "R1 rx ctrl");
    rd(4'h0, d); check(d, 32'h0, "R1 tx ctrl");
    rd(4'h9, d); check(d, 32'h0140_0000, "R1 empty status");
    check(32'(irq), 0, "R1 irq");
    check(32'(rx_ready), 0, "R1 rx_ready");

    // R5: disabled receiver takes nothing
    push(8'hAA); push(8'hAB);
    rd(4'h9, d); check(d, 32'h0140_0000, "R5 disabled");

    // enable, fill three
    wr(4'h2, 32'h8);
    push(8'h11); push(8'h22); push(8'h33);
    rd(4'h9, d); check(d, 32'h0141_0011, "R4 peek1");
    rd(4'h9, d); check(d, 32'h0141_0011, "R4 peek2");
    rd(4'h8, d); check(d, 32'h0141_0011, "R4 pop");
    rd(4'h9, d); check(d, 32'h0141_0022, "R4 after pop");
    wr(4'hB, 32'h8);
    check(32'(irq), 1, "R9 rx irq");

    // R2: fill to 16, then one more is refused
    for (int i = 0; i < 14; i++) push(8'h40 + 8'(i));
    check(32'(rx_ready), 0, "R2 full stall");
    push(8'hEE);
    rd(4'h8, d); check(d, 32'h0141_0022, "R2 order0");
    rd(4'h8, d); check(d, 32'h0141_0033, "R2 order1");
    for (int i = 0; i < 14; i++) begin
      rd(4'h8, d); check(d, 32'h0141_0040 + 32'(i), "R2 order");
    end
    rd(4'h8, d); check(d, 32'h0140_0000, "R2 drop after full");

    // R8: pop-only leaves bit 3, a write refreshes it
    rd(4'hD, d); check(d, 32'h8, "R8 stale");
    wr(4'h0, 32'h5);
    rd(4'hD, d); check(d, 32'h0, "R8 refreshed");
    rd(4'h0, d); check(d, 32'h5, "R10 tx ctrl");

    // R11: push and pop together
    push(8'h55);
    rx_valid = 1; rx_data = 8'h66;
    rd(4'h8, d); rx_valid = 0;
    check(d, 32'h0141_0055, "R11 pop during push");
    rd(4'h9, d); check(d, 32'h0141_0066, "R11 order");
    rd(4'h8, d);
    rd(4'h9, d); check(d, 32'h0140_0000, "R11 count");

    // R6 / R7 transmit and acknowledge one-shot
    wr(4'hB, 32'h3);
    wr(4'h7, 32'h1234_56A5);
    rd(4'hD, d); check(d, 32'h3, "R6 raw set");
    rd(4'h7, d); check(d, 32'h1234_56A5, "R6 readback");
    rd(4'hE, d); check(d, 32'h3, "R9 masked");
    wr(4'hC, 32'h3);
    rd(4'hD, d); check(d, 32'h1, "R7 bit0 spared");
    rd(4'hC, d); check(d, 32'h2, "R7 applied value");
    wr(4'hC, 32'h1);
    rd(4'hD, d); check(d, 32'h0, "R7 second ack");
    check(32'(irq), 0, "R9 irq cleared");

    // R10: read-only and unmapped words
    wr(4'hD, 32'hFFFF_FFFF);
    rd(4'hD, d); check(d, 32'h0, "R10 raw read-only");
    wr(4'h4, 32'hFF);
    rd(4'h4, d); check(d, 32'h0, "R10 unmapped");
    wr(4'h1, 32'hA5A5);
    rd(4'h1, d); check(d, 32'hA5A5, "R10 dma word");

    // R5: disable again
    wr(4'h2, 32'h0);
    push(8'h77);
    rd(4'h9, d); check(d, 32'h0140_0000, "R5 disabled again");

    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule